// File: doc/BRIEF.md
# Dual-Channel Storage Host Register Bank

This block holds the control and status registers of a two-channel storage host controller behind a 512-byte, byte-addressed register window. Each channel has the following registers:

- a bus-master command byte;
- a six-bit scratch byte;
- a bus-master status byte, which mixes live, sticky and write-one-to-clear bits;
- a read-only configuration/status word that carries the channel interrupt flag;
- a 12-bit link control word;
- a masked 16-bit interrupt-enable field.

Two summary words gather the command, status and interrupt state of the channels into single 32-bit reads. The two channel interrupt flags are merged into one interrupt line.

The DMA engine, the task-file registers and the serial link sit outside the block. The DMA engine reports back through an activity level and two set pulses per channel. Task-file accesses leave the block as a per-channel strobe that carries the low offset bits. A write of the link control word with bit 0 set produces a one-cycle bus-reset pulse for that channel, and reset produces one for both channels.

Reads are combinational: `rdata_o` is valid in the same cycle that `acc_vld_i` is high with `acc_wr_i` low, and is zero otherwise. Writes take effect at the clock edge. Byte registers take `acc_wdata_i[7:0]`, and word registers take the full word.

Top module: `stor_csr_bank`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, `bus_rst_o` is 2'b11. After that edge it is 2'b00. Reset sets both configuration/status words (reads at 0x0A0 and 0x0E0) to 0x6515_0000, and sets command, scratch and stored status bits to zero.
- R2: A scratch write at 0x01 or 0x11 (channel 0), or at 0x09 or 0x19 (channel 1), stores `acc_wdata_i[5:0]`. A read at 0x01 or 0x09 returns the stored value zero-extended.
- R3: A status write at 0x02/0x12 (channel 0) or 0x0A/0x1A (channel 1) loads bits 6:5 from the data. It clears bit 2 and bit 1 wherever the data bit is 1 and keeps them otherwise. It does not change bit 0. Bits 7, 4 and 3 read as zero.
- R4: Status bit 0 reads the live `bm_active_i` of its channel. A `bm_err_set_i` pulse sets status bit 1 and a `bm_int_set_i` pulse sets status bit 2. A set pulse wins over a clear in the same cycle.
- R5: A write at 0x100 (channel 0) or 0x180 (channel 1) stores data bits 11:0, which are read back at the same offset. If data bit 0 is 1, that channel's `bus_rst_o` bit is high for exactly the one cycle after the write edge.
- R6: A write at 0x148 (channel 0) or 0x1C8 (channel 1) stores data bits 31:16 ANDed with 0x3EED. A read at the same offset returns the stored value in bits 31:16 and zeros below.
- R7: Bit 11 of a channel's configuration/status word follows `chan_irq_i` of that channel one clock later and cannot be written. `irq_o` is the OR of the two bit-11 flags.
- R8: A read at 0x10 returns the following fields:
  - channel 0 command in bits 7:0;
  - channel 0 interrupt flag ORed into bit 4;
  - channel 1 interrupt flag ORed into bit 6;
  - channel 1 status bit 2 in bit 14;
  - channel 0 status in bits 23:16;
  - channel 1 status in bits 31:24.
- R9: A read at 0x18 returns the channel 1 command in bits 7:0, the channel 1 interrupt flag ORed into bit 4, and the channel 1 status in bits 23:16.
- R10: A read at 0x104 (channel 0) or 0x184 (channel 1) returns 0x113 when that channel's `dev_present_i` bit is 1, and 0 otherwise.
- R11: Reads of 0x03, 0x0B and every unmapped offset return 0. Writes to unmapped offsets change no register.
- R12: An access at 0x80–0x87 or 0x8A (channel 0), or at 0xC0–0xC7 or 0xCA (channel 1), raises `tf_stb_o[channel]` in the same cycle. During that access `tf_off_o` is `acc_addr_i[3:0]`, `tf_wr_o` is `acc_wr_i` and `tf_size_o` is `acc_size_i`. At every other offset `tf_stb_o` stays 0.
- R13: A command write at 0x00 or 0x10 sets the channel 0 command byte, and a write at 0x08 or 0x18 sets the channel 1 command byte. The byte reads back at 0x00 or 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | Access valid |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 9 | Byte offset in the window |
| acc_size_i | input | 2 | Access size code (log2 bytes), passed to task-file strobe |
| acc_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| bm_active_i | input | 2 | Per-channel DMA active level |
| bm_err_set_i | input | 2 | Per-channel error set pulse |
| bm_int_set_i | input | 2 | Per-channel DMA interrupt set pulse |
| chan_irq_i | input | 2 | Per-channel interrupt request level |
| dev_present_i | input | 2 | Per-channel device present |
| irq_o | output | 1 | Merged interrupt |
| bus_rst_o | output | 2 | Per-channel bus-reset pulse |
| tf_stb_o | output | 2 | Per-channel task-file access strobe |
| tf_off_o | output | 4 | Task-file offset |
| tf_wr_o | output | 1 | Task-file access is a write |
| tf_size_o | output | 2 | Task-file access size |

## Verification
The hardest state to reach is a status byte that holds every kind of bit at once: a live bit 0, sticky bits 1 and 2, and bits 6:5 loaded by software. Only that state shows whether a single write clears, keeps and loads the right bits.

The bench gets there in stages. It raises both sticky bits with DMA set pulses and holds the activity input high. It then writes a pattern that clears one sticky bit and sets the software bits, and follows with a write that sets bit 0 in the data and must not touch the live bit.

The summary words are checked afterwards, with interrupt requests raised on one channel at a time. This shows that each channel flag lands in its own bit position.

// File: rtl/stor_pkg.sv
package stor_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;
  localparam int LNK_W  = 12;
  localparam int IEN_W  = 16;
  localparam logic [DATA_W-1:0] CONF_RST = 32'h6515_0000;
  localparam logic [IEN_W-1:0]  IEN_MASK = 16'h3EED;
  localparam logic [DATA_W-1:0] LINK_UP  = 32'h0000_0113;
  localparam int IRQ_BIT = 11;
endpackage

// File: rtl/stor_chan.sv
module stor_chan
  import stor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_scr_i,
  input  logic              wr_sts_i,
  input  logic              wr_lnk_i,
  input  logic              wr_ien_i,
  input  logic [7:0]        wbyte_i,
  input  logic [LNK_W-1:0]  wlnk_i,
  input  logic [IEN_W-1:0]  wien_i,
  input  logic              bm_active_i,
  input  logic              bm_err_set_i,
  input  logic              bm_int_set_i,
  input  logic              irq_i,
  output logic [7:0]        cmd_o,
  output logic [5:0]        scr_o,
  output logic [7:0]        sts_o,
  output logic [LNK_W-1:0]  lnk_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic [DATA_W-1:0] conf_o,
  output logic              irq_flag_o,
  output logic              bus_rst_o
);
  logic       err_q, int_q, irq_q, brst_q;
  logic [1:0] sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= '0;
      scr_o  <= '0;
      sw_q   <= '0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      lnk_o  <= '0;
      ien_o  <= '0;
      irq_q  <= 1'b0;
      brst_q <= 1'b1;  // reset issues a bus reset
    end else begin
      if (wr_cmd_i) cmd_o <= wbyte_i;
      if (wr_scr_i) scr_o <= wbyte_i[5:0];
      if (wr_sts_i) sw_q <= wbyte_i[6:5];
      // set pulse wins over software clear
      err_q  <= (err_q & ~(wr_sts_i & wbyte_i[1])) | bm_err_set_i;
      int_q  <= (int_q & ~(wr_sts_i & wbyte_i[2])) | bm_int_set_i;
      if (wr_lnk_i) lnk_o <= wlnk_i;
      if (wr_ien_i) ien_o <= wien_i & IEN_MASK;
      irq_q  <= irq_i;
      brst_q <= wr_lnk_i & wlnk_i[0];
    end
  end

  assign sts_o      = {1'b0, sw_q, 2'b00, int_q, err_q, bm_active_i};
  assign irq_flag_o = irq_q;
  assign conf_o     = CONF_RST | (DATA_W'(irq_q) << IRQ_BIT);
  assign bus_rst_o  = brst_q;

  p_w1c_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && wbyte_i[2] && !bm_int_set_i) |=> !sts_o[2]);
  p_sticky_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_err_set_i |=> sts_o[1]);
  p_brst_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lnk_i && wlnk_i[0]) |=> bus_rst_o);
  p_brst_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lnk_i && wlnk_i[0]) |=> !bus_rst_o);
  p_ien_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ien_i |=> $stable(ien_o));
  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> irq_flag_o);
  p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |=> !irq_flag_o);
endmodule

// File: rtl/stor_rdmux.sv
module stor_rdmux
  import stor_pkg::*;
(
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NCH-1:0][7:0]         cmd_i,
  input  logic [NCH-1:0][5:0]         scr_i,
  input  logic [NCH-1:0][7:0]         sts_i,
  input  logic [NCH-1:0][LNK_W-1:0]   lnk_i,
  input  logic [NCH-1:0][IEN_W-1:0]   ien_i,
  input  logic [NCH-1:0][DATA_W-1:0]  conf_i,
  input  logic [NCH-1:0]              irq_flag_i,
  input  logic [NCH-1:0]              dev_present_i,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] sum0, sum1;

  always_comb begin
    sum0 = {sts_i[1], sts_i[0], 1'b0, sts_i[1][2], 6'b0, cmd_i[0]};
    sum0[4] = sum0[4] | irq_flag_i[0];
    sum0[6] = sum0[6] | irq_flag_i[1];
    sum1 = {8'b0, sts_i[1], 8'b0, cmd_i[1]};
    sum1[4] = sum1[4] | irq_flag_i[1];
  end

  always_comb begin
    unique case (addr_i)
      9'h000:  rdata_o = DATA_W'(cmd_i[0]);
      9'h001:  rdata_o = DATA_W'(scr_i[0]);
      9'h002:  rdata_o = DATA_W'(sts_i[0]);
      9'h008:  rdata_o = DATA_W'(cmd_i[1]);
      9'h009:  rdata_o = DATA_W'(scr_i[1]);
      9'h00A:  rdata_o = DATA_W'(sts_i[1]);
      9'h010:  rdata_o = sum0;
      9'h018:  rdata_o = sum1;
      9'h0A0:  rdata_o = conf_i[0];
      9'h0E0:  rdata_o = conf_i[1];
      9'h100:  rdata_o = DATA_W'(lnk_i[0]);
      9'h180:  rdata_o = DATA_W'(lnk_i[1]);
      9'h104:  rdata_o = dev_present_i[0] ? LINK_UP : '0;
      9'h184:  rdata_o = dev_present_i[1] ? LINK_UP : '0;
      9'h148:  rdata_o = {ien_i[0], 16'h0};
      9'h1C8:  rdata_o = {ien_i[1], 16'h0};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/stor_csr_bank.sv
module stor_csr_bank
  import stor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic              acc_wr_i,
  input  logic [8:0]        acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [31:0]       acc_wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [1:0]        bm_active_i,
  input  logic [1:0]        bm_err_set_i,
  input  logic [1:0]        bm_int_set_i,
  input  logic [1:0]        chan_irq_i,
  input  logic [1:0]        dev_present_i,
  output logic              irq_o,
  output logic [1:0]        bus_rst_o,
  output logic [1:0]        tf_stb_o,
  output logic [3:0]        tf_off_o,
  output logic              tf_wr_o,
  output logic [1:0]        tf_size_o
);
  logic [NCH-1:0][7:0]        cmd, sts;
  logic [NCH-1:0][5:0]        scr;
  logic [NCH-1:0][LNK_W-1:0]  lnk;
  logic [NCH-1:0][IEN_W-1:0]  ien;
  logic [NCH-1:0][DATA_W-1:0] conf;
  logic [NCH-1:0]             irq_flag;
  logic [DATA_W-1:0]          rd_raw;
  logic                       wen, ren;
  logic                       byte_blk;
  logic                       unused_wdata;

  assign wen      = acc_vld_i & acc_wr_i;
  assign ren      = acc_vld_i & ~acc_wr_i;
  // 0x00-0x03, 0x08-0x0B and their 0x10 aliases
  assign byte_blk = (acc_addr_i[8:5] == 4'h0) & ~acc_addr_i[2];
  assign unused_wdata = ^acc_wdata_i[15:LNK_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [8:0] LNK_A = 9'h100 + 9'(c * 128);
    localparam logic [8:0] IEN_A = 9'h148 + 9'(c * 128);
    localparam logic [8:0] TF_A  = 9'h080 + 9'(c * 64);
    logic sel, tf_hit;
    assign sel    = byte_blk & (acc_addr_i[3] == 1'(c));
    assign tf_hit = (acc_addr_i[8:3] == TF_A[8:3]) |
                    (acc_addr_i == (TF_A | 9'h00A));
    assign tf_stb_o[c] = acc_vld_i & tf_hit;

    stor_chan u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_cmd_i     (wen & sel & (acc_addr_i[1:0] == 2'd0)),
      .wr_scr_i     (wen & sel & (acc_addr_i[1:0] == 2'd1)),
      .wr_sts_i     (wen & sel & (acc_addr_i[1:0] == 2'd2)),
      .wr_lnk_i     (wen & (acc_addr_i == LNK_A)),
      .wr_ien_i     (wen & (acc_addr_i == IEN_A)),
      .wbyte_i      (acc_wdata_i[7:0]),
      .wlnk_i       (acc_wdata_i[LNK_W-1:0]),
      .wien_i       (acc_wdata_i[31:16]),
      .bm_active_i  (bm_active_i[c]),
      .bm_err_set_i (bm_err_set_i[c]),
      .bm_int_set_i (bm_int_set_i[c]),
      .irq_i        (chan_irq_i[c]),
      .cmd_o        (cmd[c]),
      .scr_o        (scr[c]),
      .sts_o        (sts[c]),
      .lnk_o        (lnk[c]),
      .ien_o        (ien[c]),
      .conf_o       (conf[c]),
      .irq_flag_o   (irq_flag[c]),
      .bus_rst_o    (bus_rst_o[c])
    );
  end

  stor_rdmux u_rdmux (
    .addr_i        (acc_addr_i),
    .cmd_i         (cmd),
    .scr_i         (scr),
    .sts_i         (sts),
    .lnk_i         (lnk),
    .ien_i         (ien),
    .conf_i        (conf),
    .irq_flag_i    (irq_flag),
    .dev_present_i (dev_present_i),
    .rdata_o       (rd_raw)
  );

  assign rdata_o   = ren ? rd_raw : '0;
  assign irq_o     = |irq_flag;
  assign tf_off_o  = acc_addr_i[3:0];
  assign tf_wr_o   = acc_wr_i;
  assign tf_size_o = acc_size_i;

  p_tf_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tf_stb_o));
  p_tf_needs_vld_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_i |-> (tf_stb_o == 2'b00));
  p_irq_merge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_irq_i != 2'b00) |=> irq_o);
endmodule

// File: tb/tb_stor_csr_bank.sv
module tb_stor_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  bm_act = '0, bm_err = '0, bm_int = '0, irq_in = '0, devp = '0;
  logic        irq;
  logic [1:0]  brst, tf_stb, tf_size;
  logic [3:0]  tf_off;
  logic        tf_wr;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  stor_csr_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(vld), .acc_wr_i(wr),
    .acc_addr_i(addr), .acc_size_i(size), .acc_wdata_i(wdata), .rdata_o(rdata),
    .bm_active_i(bm_act), .bm_err_set_i(bm_err), .bm_int_set_i(bm_int),
    .chan_irq_i(irq_in), .dev_present_i(devp), .irq_o(irq), .bus_rst_o(brst),
    .tf_stb_o(tf_stb), .tf_off_o(tf_off), .tf_wr_o(tf_wr), .tf_size_o(tf_size)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = a; wdata = d; size = 2'd2;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
  endtask

  task automatic do_rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    vld = 1'b0;
  endtask

  task automatic pulse(ref logic [1:0] s, input logic [1:0] v);
    @(negedge clk); s = v;
    @(negedge clk); s = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #10 chk("R1 brst in reset", 32'(brst), 32'h3);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 brst before edge", 32'(brst), 32'h3);
    @(negedge clk);
    chk("R1 brst after edge", 32'(brst), 32'h0);
    do_rd(9'h0A0, d); chk("R1 conf0", d, 32'h6515_0000);
    do_rd(9'h0E0, d); chk("R1 conf1", d, 32'h6515_0000);
    do_rd(9'h002, d); chk("R1 sts0", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_scratch;
    logic [31:0] d;
    do_wr(9'h001, 32'hFF); do_rd(9'h001, d); chk("R2 scr0", d, 32'h3F);
    do_wr(9'h019, 32'hAA); do_rd(9'h009, d); chk("R2 scr1 alias", d, 32'h2A);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    do_wr(9'h010, 32'h05); do_rd(9'h000, d); chk("R13 cmd0 alias", d, 32'h05);
    do_wr(9'h008, 32'h09); do_rd(9'h008, d); chk("R13 cmd1", d, 32'h09);
  endtask

  task automatic t_status;
    logic [31:0] d;
    pulse(bm_err, 2'b01); pulse(bm_int, 2'b01);
    do_rd(9'h002, d); chk("R4 sticky set", d, 32'h06);
    bm_act = 2'b01;
    do_wr(9'h012, 32'h64);
    do_rd(9'h002, d); chk("R3 w1c and load", d, 32'h63);
    do_wr(9'h002, 32'h01);
    do_rd(9'h002, d); chk("R3 bit0 kept", d, 32'h03);
    bm_act = 2'b00;
    do_rd(9'h002, d); chk("R4 bit0 live", d, 32'h02);
  endtask

  task automatic t_link;
    logic [31:0] d;
    do_wr(9'h100, 32'hFFFF_F0A1);
    chk("R5 pulse", 32'(brst), 32'h1);
    @(negedge clk);
    chk("R5 single cycle", 32'(brst), 32'h0);
    do_rd(9'h100, d); chk("R5 lnk0", d, 32'h0A1);
    do_wr(9'h180, 32'h0000_0F02);
    chk("R5 no pulse", 32'(brst), 32'h0);
    do_rd(9'h180, d); chk("R5 lnk1", d, 32'hF02);
  endtask

  task automatic t_ien;
    logic [31:0] d;
    do_wr(9'h148, 32'hFFFF_0000); do_rd(9'h148, d); chk("R6 ien0", d, 32'h3EED_0000);
    do_wr(9'h1C8, 32'h1234_FFFF); do_rd(9'h1C8, d); chk("R6 ien1", d, 32'h1224_0000);
  endtask

  task automatic t_irq_summary;
    logic [31:0] d;
    pulse(bm_int, 2'b10);
    @(negedge clk); irq_in = 2'b01;
    @(negedge clk);
    chk("R7 irq ch0", 32'(irq), 32'h1);
    do_rd(9'h0A0, d); chk("R7 conf0 flag", d, 32'h6515_0800);
    do_rd(9'h010, d); chk("R8 summary ch0 flag", d, 32'h0402_4015);
    irq_in = 2'b10;
    @(negedge clk);
    chk("R7 irq ch1", 32'(irq), 32'h1);
    do_rd(9'h010, d); chk("R8 summary ch1 flag", d, 32'h0402_4045);
    do_rd(9'h018, d); chk("R9 summary1", d, 32'h0004_0019);
    do_wr(9'h0E0, 32'h0);
    do_rd(9'h0E0, d); chk("R7 conf1 not writable", d, 32'h6515_0800);
    irq_in = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R7 irq clear", 32'(irq), 32'h0);
  endtask

  task automatic t_linkstat;
    logic [31:0] d;
    devp = 2'b01;
    do_rd(9'h104, d); chk("R10 ch0 up", d, 32'h113);
    do_rd(9'h184, d); chk("R10 ch1 down", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    do_wr(9'h003, 32'hFF); do_wr(9'h040, 32'hFFFF_FFFF); do_wr(9'h011 + 9'h100, 32'hFF);
    do_rd(9'h003, d); chk("R11 rd 0x03", d, 32'h0);
    do_rd(9'h00B, d); chk("R11 rd 0x0B", d, 32'h0);
    do_rd(9'h040, d); chk("R11 rd 0x40", d, 32'h0);
    do_rd(9'h001, d); chk("R11 scr0 untouched", d, 32'h3F);
    do_rd(9'h000, d); chk("R11 cmd0 untouched", d, 32'h05);
  endtask

  task automatic t_taskfile;
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; addr = 9'h085; size = 2'd0;
    #1 chk("R12 stb ch0", {26'b0, tf_stb, tf_off}, {26'b0, 2'b01, 4'h5});
    chk("R12 rd dir", 32'(tf_wr), 32'h0);
    @(negedge clk);
    wr = 1'b1; addr = 9'h0CA; size = 2'd1;
    #1 chk("R12 stb ch1", {25'b0, tf_stb, tf_off, tf_wr}, {25'b0, 2'b10, 4'hA, 1'b1});
    chk("R12 size", 32'(tf_size), 32'h1);
    @(negedge clk);
    wr = 1'b0; addr = 9'h088;
    #1 chk("R12 no stb", 32'(tf_stb), 32'h0);
    vld = 1'b0;
  endtask

  initial begin
    t_reset();
    t_scratch();
    t_cmd();
    t_status();
    t_link();
    t_ien();
    t_irq_summary();
    t_linkstat();
    t_unmapped();
    t_taskfile();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule